// File: doc/BRIEF.md
# No-Wait Pipelined Burst SRAM

A synchronous static RAM whose address, control and byte-enable inputs are all captured on the rising clock edge. Write data arrives two enabled cycles after its address, the same distance at which read data leaves. The shared data bus can therefore carry a read in one slot and a write in the next, in either order, with no idle slot between them.

Three chip selects qualify every load cycle. A load cycle starts a read, a write or a deselect. An advance cycle repeats that kind of operation at the next address of a four-beat burst. The burst walks the two low address bits in linear or in interleaved order, as set by a mode pin. A low clock enable lets the array run; a high one freezes it completely.

A read that hits a word whose write has not yet reached the array returns the pending bytes merged with the stored ones.

Top module: `nowait_burst_ram`

## Requirements
- R1: A read loaded at enabled edge n drives its word on `dq`, with `dq_oe` high, from enabled edge n+1 until enabled edge n+2, so it is captured at edge n+2.
- R2: A write loaded at enabled edge n takes its data from `dq` at enabled edge n+2.
- R3: `dq_oe` is high only in the bus slot of a read; it is low in write slots and deselect slots, and `dq` is released then.
- R4: While `cke_n` is high, every synchronous input is ignored and all state holds, including the burst counter, the pipeline, `dq_oe` and the driven read word.
- R5: A load is a selected operation only when `ce1`=1, `ce2`=1 and `ce3_n`=0; any other combination makes a deselect that neither writes nor drives the bus.
- R6: With `mode`=0, beat i of a burst (i = 0..3) uses low address bits (start + i) mod 4; the upper bits stay those of the loaded address.
- R7: With `mode`=1, beat i of a burst uses low address bits start XOR i; the upper bits stay those of the loaded address.
- R8: `bw_n[b]`=0 writes bits [b*LANE_W +: LANE_W] of the word; a lane with `bw_n[b]`=1 keeps its stored value. `bw_n` is sampled with each address.
- R9: Reads and writes may alternate on consecutive enabled cycles in either order, and each read returns the latest data written to its address.
- R10: A read loaded on the enabled cycle right after a write to the same address returns the new data of the enabled lanes and the stored data of the other lanes.
- R11: A deselect load ends any burst in progress; each later advance cycle stays a deselect until the next load.
- R12: A synchronous reset (`rst_n`=0) clears the pipeline and the burst state: `dq_oe` is low afterwards, and advance cycles before the first load are deselects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high freezes the block |
| adv | input | 1 | 1 = advance the burst, 0 = load a new address |
| we_n | input | 1 | Write strobe on load cycles, active low |
| ce1 | input | 1 | Chip select, active high |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address for load cycles |
| bw_n | input | LANES | Per-lane write enables, active low |
| dq | inout | LANES*LANE_W | Shared data bus |
| dq_oe | output | 1 | High while the block drives `dq` |

## Verification
Bursts are first written in linear order and in interleaved order, starting from different offsets, and are then read back as bursts and as single loads. A wrong beat order therefore shows up as wrong data. Tightly alternating reads and writes follow. Some of them hit the word written one cycle earlier, with full and partial lane masks, which separates correct forwarding from stale array reads. Loads with each chip select dropped in turn, deselects in the middle of a burst with tempting advance cycles after them, and stalls placed on read slots and on write slots separate genuine ignoring and holding from partial effects.

// File: rtl/nowait_burst_ram.sv
module nowait_burst_ram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke_n,
  input  logic                    adv,
  input  logic                    we_n,
  input  logic                    ce1,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        bw_n,
  inout  wire  [LANES*LANE_W-1:0] dq,
  output logic                    dq_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR} op_e;

  logic [DW-1:0]     mem [DEPTH];
  op_e               b_op, s1_op, s2_op, new_op;
  logic [ADDR_W-1:0] b_base, s1_addr, s2_addr, new_addr;
  logic [1:0]        b_cnt, nxt_cnt, burst_lo;
  logic [LANES-1:0]  s1_bw, s2_bw;
  logic [DW-1:0]     rdata, fwd;
  logic              sel, hit;

  assign sel      = ce1 & ce2 & ~ce3_n;
  assign nxt_cnt  = b_cnt + 2'd1;
  assign burst_lo = mode ? (b_base[1:0] ^ nxt_cnt) : (b_base[1:0] + nxt_cnt);
  assign new_addr = adv ? {b_base[ADDR_W-1:2], burst_lo} : addr;
  assign hit      = (s2_op == OP_WR) && (s2_addr == s1_addr);

  always_comb begin
    if (adv)       new_op = b_op;
    else if (!sel) new_op = OP_NONE;
    else if (we_n) new_op = OP_RD;
    else           new_op = OP_WR;
  end

  always_comb begin
    fwd = mem[s1_addr];
    for (int i = 0; i < LANES; i++)
      if (hit && !s2_bw[i]) fwd[i*LANE_W +: LANE_W] = dq[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_op  <= OP_NONE;
      s1_op <= OP_NONE;
      s2_op <= OP_NONE;
      b_cnt <= '0;
    end else if (!cke_n) begin
      s1_op   <= new_op;
      s1_addr <= new_addr;
      s1_bw   <= bw_n;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_bw   <= s1_bw;
      if (adv) begin
        b_cnt <= nxt_cnt;
      end else begin
        b_op   <= new_op;
        b_base <= addr;
        b_cnt  <= '0;
      end
      if (s1_op == OP_RD) rdata <= fwd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !cke_n && s2_op == OP_WR)
      for (int i = 0; i < LANES; i++)
        if (!s2_bw[i]) mem[s2_addr][i*LANE_W +: LANE_W] <= dq[i*LANE_W +: LANE_W];
  end

  assign dq_oe = (s2_op == OP_RD);
  assign dq    = dq_oe ? rdata : 'z;
endmodule

module nowait_burst_ram_chk (
  input logic clk,
  input logic rst_n,
  input logic cke_n,
  input logic adv,
  input logic we_n,
  input logic ce1,
  input logic ce2,
  input logic ce3_n,
  input logic dq_oe
);
  logic picked;
  assign picked = ce1 & ce2 & ~ce3_n;

  a_r4_stall_holds_oe: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(dq_oe));

  a_r1_read_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && picked && we_n) ##1 !cke_n |=> dq_oe);

  a_r3_write_slot_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && picked && !we_n) ##1 !cke_n |=> !dq_oe);

  a_r5_deselect_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && !picked) ##1 !cke_n |=> !dq_oe);

  a_r11_advance_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && !picked) ##1 (!cke_n && adv) ##1 !cke_n |=> !dq_oe);
endmodule

bind nowait_burst_ram nowait_burst_ram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .we_n(we_n),
  .ce1(ce1), .ce2(ce2), .ce3_n(ce3_n), .dq_oe(dq_oe)
);

// File: tb/nowait_burst_ram_bench.sv
`timescale 1ns/1ps
module nowait_burst_ram_bench;
  localparam int AW = 6;
  localparam int W  = 18;

  typedef struct packed {
    logic       hold;
    logic       adv;
    logic       wen;
    logic [2:0] ce;
    logic [1:0] bwn;
    logic       mode;
    logic [5:0] addr;
  } vec_t;

  typedef struct packed {
    logic [1:0]    kind;
    logic [AW-1:0] a;
    logic [1:0]    bwn;
    logic [W-1:0]  d;
  } rec_t;

  localparam logic [1:0] K_NONE = 2'd0, K_RD = 2'd1, K_WR = 2'd2;
  localparam logic [2:0] OK = 3'b110;
  localparam int NV = 58;

  localparam vec_t VEC [NV] = '{
    {1'b0,1'b0,1'b0,OK,2'b00,1'b0,6'd0},   // R2 R6 linear write burst from 0
    {1'b0,1'b1,1'b0,OK,2'b00,1'b0,6'd0},
    {1'b0,1'b1,1'b0,OK,2'b00,1'b0,6'd0},
    {1'b0,1'b1,1'b0,OK,2'b00,1'b0,6'd0},
    {1'b0,1'b0,1'b0,OK,2'b00,1'b1,6'd9},   // R7 interleaved write burst from 9
    {1'b0,1'b1,1'b0,OK,2'b00,1'b1,6'd9},
    {1'b0,1'b1,1'b0,OK,2'b00,1'b1,6'd9},
    {1'b0,1'b1,1'b0,OK,2'b00,1'b1,6'd9},
    {1'b0,1'b0,1'b0,OK,2'b00,1'b0,6'd14},  // R6 linear write burst wrapping from 14
    {1'b0,1'b1,1'b0,OK,2'b00,1'b0,6'd14},
    {1'b0,1'b1,1'b0,OK,2'b00,1'b0,6'd14},
    {1'b0,1'b1,1'b0,OK,2'b00,1'b0,6'd14},
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd0},   // R1 R6 linear read burst
    {1'b0,1'b1,1'b1,OK,2'b00,1'b0,6'd0},
    {1'b0,1'b1,1'b1,OK,2'b00,1'b0,6'd0},
    {1'b0,1'b1,1'b1,OK,2'b00,1'b0,6'd0},
    {1'b0,1'b0,1'b1,OK,2'b00,1'b1,6'd10},  // R7 interleaved read burst from 10
    {1'b0,1'b1,1'b1,OK,2'b00,1'b1,6'd10},
    {1'b0,1'b1,1'b1,OK,2'b00,1'b1,6'd10},
    {1'b0,1'b1,1'b1,OK,2'b00,1'b1,6'd10},
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd13},  // R6 linear read burst from 13
    {1'b0,1'b1,1'b1,OK,2'b00,1'b0,6'd13},
    {1'b0,1'b1,1'b1,OK,2'b00,1'b0,6'd13},
    {1'b0,1'b1,1'b1,OK,2'b00,1'b0,6'd13},
    {1'b0,1'b0,1'b0,OK,2'b00,1'b0,6'd20},  // R9 alternating writes and reads
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd1},
    {1'b0,1'b0,1'b0,OK,2'b00,1'b0,6'd21},
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd20},
    {1'b0,1'b0,1'b0,OK,2'b00,1'b0,6'd22},
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd22},  // R10 full-word forward
    {1'b0,1'b0,1'b0,OK,2'b10,1'b0,6'd22},  // R8 lane 0 only
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd22},  // R10 merged forward
    {1'b0,1'b0,1'b0,OK,2'b01,1'b0,6'd22},  // R8 lane 1 only
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd21},
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd22},  // R8 merged array word
    {1'b0,1'b0,1'b0,3'b010,2'b00,1'b0,6'd23}, // R5 ce1 low
    {1'b0,1'b0,1'b0,3'b111,2'b00,1'b0,6'd23}, // R5 ce3_n high
    {1'b0,1'b0,1'b0,3'b100,2'b00,1'b0,6'd23}, // R5 ce2 low
    {1'b0,1'b0,1'b0,OK,2'b00,1'b0,6'd23},
    {1'b0,1'b0,1'b0,3'b010,2'b00,1'b0,6'd23}, // R5 deselected write must not land
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd23},
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd0},   // R11 burst cut by deselect
    {1'b0,1'b1,1'b1,OK,2'b00,1'b0,6'd0},
    {1'b0,1'b0,1'b1,3'b000,2'b00,1'b0,6'd0},
    {1'b0,1'b1,1'b1,OK,2'b00,1'b0,6'd0},
    {1'b0,1'b1,1'b1,OK,2'b00,1'b0,6'd0},
    {1'b0,1'b1,1'b0,OK,2'b00,1'b0,6'd2},
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd2},   // R11 word 2 untouched
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd3},
    {1'b1,1'b0,1'b0,OK,2'b00,1'b0,6'd3},   // R4 stall on a read slot
    {1'b1,1'b0,1'b0,OK,2'b00,1'b0,6'd3},
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd9},
    {1'b0,1'b0,1'b0,OK,2'b00,1'b0,6'd30},
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd1},
    {1'b1,1'b0,1'b0,OK,2'b00,1'b0,6'd30},  // R4 stall on a write slot
    {1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd30},
    {1'b0,1'b0,1'b1,3'b000,2'b00,1'b0,6'd0},
    {1'b0,1'b0,1'b1,3'b000,2'b00,1'b0,6'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, cke_n = 1'b0, adv = 1'b0, we_n = 1'b1;
  logic ce1 = 1'b0, ce2 = 1'b0, ce3_n = 1'b1, mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0] bw_n = 2'b11;
  logic [W-1:0] tb_d = '0;
  logic tb_en = 1'b0;
  wire  [W-1:0] dq;
  logic dq_oe;

  assign dq = tb_en ? tb_d : 'z;

  nowait_burst_ram #(.ADDR_W(AW), .LANES(2), .LANE_W(9)) u_nowait_burst_ram (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .we_n(we_n),
    .ce1(ce1), .ce2(ce2), .ce3_n(ce3_n), .mode(mode), .addr(addr),
    .bw_n(bw_n), .dq(dq), .dq_oe(dq_oe)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, idx = 0;
  bit done = 0;
  logic [W-1:0] mdl [1<<AW];
  rec_t p1, p2;
  logic [1:0] bop, bcnt;
  logic [AW-1:0] bbase;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic clear_model();
    p1 = '0; p2 = '0; bop = K_NONE; bcnt = 2'd0; bbase = '0;
  endtask

  task automatic step(input vec_t v);
    rec_t n;
    logic [1:0] lo;
    @(negedge clk);
    cke_n = v.hold; adv = v.adv; we_n = v.wen;
    {ce1, ce2, ce3_n} = v.ce; bw_n = v.bwn; mode = v.mode; addr = v.addr;
    tb_en = (p2.kind == K_WR);
    tb_d  = p2.d;
    #1;
    chk(v.hold ? "R4 dq_oe held" : "R3 dq_oe", {17'd0, dq_oe}, {17'd0, p2.kind == K_RD});
    if (p2.kind == K_RD)
      chk(v.hold ? "R4 held read word" : "R1 R9 read word", dq, mdl[p2.a]);
    @(posedge clk);
    if (!v.hold) begin
      if (p2.kind == K_WR) begin
        if (!p2.bwn[0]) mdl[p2.a][8:0]  = p2.d[8:0];
        if (!p2.bwn[1]) mdl[p2.a][17:9] = p2.d[17:9];
      end
      if (!v.adv) begin
        n.kind = (v.ce != OK) ? K_NONE : (v.wen ? K_RD : K_WR);
        n.a = v.addr;
        bop = n.kind; bbase = v.addr; bcnt = 2'd0;
      end else begin
        bcnt = bcnt + 2'd1;
        lo = v.mode ? (bbase[1:0] ^ bcnt) : (bbase[1:0] + bcnt);
        n.kind = bop;
        n.a = {bbase[AW-1:2], lo};
      end
      n.bwn = v.bwn;
      n.d = {idx[8:0] ^ 9'h1A5, idx[8:0] + 9'h03C};
      idx++;
      p2 = p1;
      p1 = n;
    end
    #1 tb_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 dq_oe after reset", {17'd0, dq_oe}, 18'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) step(VEC[i]);

    step({1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd0});
    step({1'b0,1'b1,1'b1,OK,2'b00,1'b0,6'd0});
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    chk("R12 dq_oe cleared by reset", {17'd0, dq_oe}, 18'd0);
    for (int i = 0; i < 4; i++) step({1'b0,1'b1,1'b1,OK,2'b00,1'b0,6'd0}); // R12 advance before any load
    step({1'b0,1'b0,1'b1,OK,2'b00,1'b0,6'd12});
    step({1'b0,1'b0,1'b1,3'b000,2'b00,1'b0,6'd0});
    step({1'b0,1'b0,1'b1,3'b000,2'b00,1'b0,6'd0});

    finish_run();
  end
endmodule